// File: doc/BRIEF.md
# PWM Period Event Interrupt Unit

This block sits beside a multi-channel PWM generator. In every PWM period it raises a sticky event flag at one point that software selects. That point is either an edge of one chosen channel's output, or a landmark of the period counter. The landmarks exist only when the counter runs center-aligned. The block also keeps a second, independent fault-brake flag. An external brake pin event or an ADC compare event sets that flag.

Each flag drives its own interrupt request, gated by its own enable. Only software clears the flags. Software pulses a clear strobe, and a hardware set in the same cycle overrides it. Channels are observed at their raw, positive-logic level, so any polarity inversion applied later at the pins does not change which edge is reported.

Top module: `pwm_evt_irq`

## Requirements
- R1: During and after reset, `pwm_flag`, `flt_flag`, `pwm_irq` and `flt_irq` are low.
- R2: With `evt_type` = 2'b00, a falling edge of channel `ch_sel` sets `pwm_flag` at the next clock edge. A falling edge is a cycle in which the channel is low and it was high in the previous cycle.
- R3: With `evt_type` = 2'b01, a rising edge of channel `ch_sel` (low the previous cycle, high now) sets `pwm_flag` at the next clock edge.
- R4: Edges on channels other than the one selected by `ch_sel` leave `pwm_flag` unchanged.
- R5: With `evt_type` = 2'b10 and `center_mode` = 1, a cycle in which `cnt_down` = 0 and `cnt` equals `period` (the center point) sets `pwm_flag` at the next clock edge. Reaching `period` while counting down does not set it.
- R6: With `evt_type` = 2'b11 and `center_mode` = 1, a cycle in which `cnt_down` = 1 and `cnt` = 0 (the end point) sets `pwm_flag` at the next clock edge.
- R7: With `center_mode` = 0 (edge-aligned), `evt_type` 2'b10 and 2'b11 never set `pwm_flag`.
- R8: Once set, `pwm_flag` stays high until a cycle with `pwm_clr` = 1, after which it is low at the next edge.
- R9: A hardware set and a software clear of the same flag in one cycle leave the flag high.
- R10: `flt_pin_evt` or `adc_cmp_evt` sets `flt_flag` at the next edge. Only `flt_clr` clears it, and it is independent of `pwm_flag`.
- R11: `pwm_irq` equals `pwm_flag` AND `pwm_irq_en`, and `flt_irq` equals `flt_flag` AND `flt_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 12 | PWM period counter value |
| period | input | 12 | PWM period value |
| center_mode | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| cnt_down | input | 1 | Counter direction in center mode, 1 = down |
| ch_lvl | input | 8 | Raw positive-logic channel levels |
| ch_sel | input | 3 | Channel watched for edge events |
| evt_type | input | 2 | 00 fall, 01 rise, 10 center, 11 end |
| flt_pin_evt | input | 1 | Brake pin event |
| adc_cmp_evt | input | 1 | ADC compare event |
| pwm_clr | input | 1 | Software clear of pwm_flag |
| flt_clr | input | 1 | Software clear of flt_flag |
| pwm_irq_en | input | 1 | PWM interrupt enable |
| flt_irq_en | input | 1 | Fault interrupt enable |
| pwm_flag | output | 1 | Sticky period event flag |
| flt_flag | output | 1 | Sticky fault-brake flag |
| pwm_irq | output | 1 | PWM interrupt request |
| flt_irq | output | 1 | Fault-brake interrupt request |

## Verification
The assertions assume that `cnt`, `period` and the direction bit come from a real period counter. They also assume that the mode and type fields are the values sampled in the same cycle as the event they qualify. No assertion tracks a configuration change across a clock edge. The stimulus changes fields only between steps, one at a time, and holds the counter away from its landmarks whenever a landmark event is not intended. The edge checks are left to the bench, which drives channel levels as explicit cycle-by-cycle sequences.

// File: rtl/pwm_evt_irq.sv
module pwm_evt_irq #(
  parameter int CW  = 12,
  parameter int NCH = 8,
  localparam int SW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cnt,
  input  logic [CW-1:0]  period,
  input  logic           center_mode,
  input  logic           cnt_down,
  input  logic [NCH-1:0] ch_lvl,
  input  logic [SW-1:0]  ch_sel,
  input  logic [1:0]     evt_type,
  input  logic           flt_pin_evt,
  input  logic           adc_cmp_evt,
  input  logic           pwm_clr,
  input  logic           flt_clr,
  input  logic           pwm_irq_en,
  input  logic           flt_irq_en,
  output logic           pwm_flag,
  output logic           flt_flag,
  output logic           pwm_irq,
  output logic           flt_irq
);

  logic [NCH-1:0] lvl_q;
  logic           primed;
  logic           pwm_set;

  wire now_lvl  = ch_lvl[ch_sel];
  wire prev_lvl = lvl_q[ch_sel];
  wire rise     = primed & now_lvl & ~prev_lvl;
  wire fall     = primed & ~now_lvl & prev_lvl;
  wire mid_pt   = center_mode & ~cnt_down & (cnt == period);
  wire end_pt   = center_mode & cnt_down & (cnt == '0);
  wire flt_set  = flt_pin_evt | adc_cmp_evt;

  always_comb begin
    case (evt_type)
      2'b00:   pwm_set = fall;
      2'b01:   pwm_set = rise;
      2'b10:   pwm_set = mid_pt;
      default: pwm_set = end_pt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      primed   <= 1'b0;
      pwm_flag <= 1'b0;
      flt_flag <= 1'b0;
    end else begin
      lvl_q    <= ch_lvl;
      primed   <= 1'b1;
      pwm_flag <= pwm_set | (pwm_flag & ~pwm_clr);
      flt_flag <= flt_set | (flt_flag & ~flt_clr);
    end
  end

  assign pwm_irq = pwm_flag & pwm_irq_en;
  assign flt_irq = flt_flag & flt_irq_en;

endmodule

module pwm_evt_irq_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] period,
  input logic          center_mode,
  input logic          cnt_down,
  input logic [1:0]    evt_type,
  input logic          flt_pin_evt,
  input logic          adc_cmp_evt,
  input logic          pwm_clr,
  input logic          flt_clr,
  input logic          pwm_flag,
  input logic          flt_flag,
  input logic          pwm_irq,
  input logic          flt_irq
);

  assert_center_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (center_mode && evt_type == 2'b10 && !cnt_down && cnt == period) |=> pwm_flag);

  assert_end_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (center_mode && evt_type == 2'b11 && cnt_down && cnt == '0) |=> pwm_flag);

  assert_edge_mode_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!center_mode && evt_type[1] && !pwm_flag) |=> !pwm_flag);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_flag && !pwm_clr) |=> pwm_flag);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clr && (flt_pin_evt || adc_cmp_evt)) |=> flt_flag);

  assert_fault_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_pin_evt || adc_cmp_evt) |=> flt_flag);

  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clr && !flt_pin_evt && !adc_cmp_evt) |=> !flt_flag);

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_irq |-> pwm_flag) and (flt_irq |-> flt_flag));

endmodule

bind pwm_evt_irq pwm_evt_irq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .period(period),
  .center_mode(center_mode), .cnt_down(cnt_down), .evt_type(evt_type),
  .flt_pin_evt(flt_pin_evt), .adc_cmp_evt(adc_cmp_evt),
  .pwm_clr(pwm_clr), .flt_clr(flt_clr),
  .pwm_flag(pwm_flag), .flt_flag(flt_flag),
  .pwm_irq(pwm_irq), .flt_irq(flt_irq)
);

// File: tb/pwm_evt_irq_tb.sv
module pwm_evt_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] cnt = 12'd50, period = 12'd100;
  logic center_mode = 1'b0, cnt_down = 1'b0;
  logic [7:0] ch_lvl = 8'h00;
  logic [2:0] ch_sel = 3'd2;
  logic [1:0] evt_type = 2'b01;
  logic flt_pin_evt = 1'b0, adc_cmp_evt = 1'b0, pwm_clr = 1'b0, flt_clr = 1'b0;
  logic pwm_irq_en = 1'b0, flt_irq_en = 1'b0;
  logic pwm_flag, flt_flag, pwm_irq, flt_irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_evt_irq u_dut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .period(period),
    .center_mode(center_mode), .cnt_down(cnt_down), .ch_lvl(ch_lvl),
    .ch_sel(ch_sel), .evt_type(evt_type), .flt_pin_evt(flt_pin_evt),
    .adc_cmp_evt(adc_cmp_evt), .pwm_clr(pwm_clr), .flt_clr(flt_clr),
    .pwm_irq_en(pwm_irq_en), .flt_irq_en(flt_irq_en),
    .pwm_flag(pwm_flag), .flt_flag(flt_flag), .pwm_irq(pwm_irq), .flt_irq(flt_irq)
  );

  // {req(4), type(2), sel(3), lvl(8), center, down, cnt(12), clr, exp}
  localparam logic [32:0] VEC [NV] = '{
    {4'd3, 2'b01, 3'd2, 8'h00, 1'b0, 1'b0, 12'd50,  1'b0, 1'b0}, // R3 no edge
    {4'd3, 2'b01, 3'd2, 8'h04, 1'b0, 1'b0, 12'd50,  1'b0, 1'b1}, // R3 rise
    {4'd8, 2'b01, 3'd2, 8'h04, 1'b0, 1'b0, 12'd50,  1'b1, 1'b0}, // R8 clear
    {4'd3, 2'b01, 3'd2, 8'h04, 1'b0, 1'b0, 12'd50,  1'b0, 1'b0}, // R3 level held
    {4'd2, 2'b00, 3'd2, 8'h00, 1'b0, 1'b0, 12'd50,  1'b0, 1'b1}, // R2 fall
    {4'd8, 2'b00, 3'd2, 8'h00, 1'b0, 1'b0, 12'd50,  1'b1, 1'b0}, // R8 clear
    {4'd4, 2'b00, 3'd2, 8'h01, 1'b0, 1'b0, 12'd50,  1'b0, 1'b0}, // R4 other ch rise
    {4'd4, 2'b00, 3'd2, 8'h00, 1'b0, 1'b0, 12'd50,  1'b0, 1'b0}, // R4 other ch fall
    {4'd5, 2'b10, 3'd2, 8'h00, 1'b1, 1'b0, 12'd100, 1'b0, 1'b1}, // R5 center
    {4'd8, 2'b10, 3'd2, 8'h00, 1'b1, 1'b0, 12'd50,  1'b1, 1'b0}, // R8 clear
    {4'd5, 2'b10, 3'd2, 8'h00, 1'b1, 1'b1, 12'd100, 1'b0, 1'b0}, // R5 down at period
    {4'd6, 2'b11, 3'd2, 8'h00, 1'b1, 1'b1, 12'd0,   1'b0, 1'b1}, // R6 end
    {4'd8, 2'b11, 3'd2, 8'h00, 1'b1, 1'b1, 12'd50,  1'b1, 1'b0}, // R8 clear
    {4'd7, 2'b11, 3'd2, 8'h00, 1'b0, 1'b1, 12'd0,   1'b0, 1'b0}, // R7 end in edge mode
    {4'd7, 2'b10, 3'd2, 8'h00, 1'b0, 1'b0, 12'd100, 1'b0, 1'b0}, // R7 center in edge mode
    {4'd9, 2'b11, 3'd2, 8'h00, 1'b1, 1'b1, 12'd0,   1'b1, 1'b1}, // R9 set beats clear
    {4'd8, 2'b11, 3'd2, 8'h00, 1'b1, 1'b1, 12'd50,  1'b1, 1'b0}  // R8 clear
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pwm_irq_en = 1'b1; flt_irq_en = 1'b1; flt_pin_evt = 1'b1;
    tick(); tick();
    check("R1 pwm_flag", pwm_flag, 1'b0);
    check("R1 flt_flag", flt_flag, 1'b0);
    check("R1 pwm_irq", pwm_irq, 1'b0);
    check("R1 flt_irq", flt_irq, 1'b0);
    flt_pin_evt = 1'b0;
    rst_n = 1'b1;
    tick();
    for (int i = 0; i < NV; i++) begin
      {evt_type, ch_sel, ch_lvl, center_mode, cnt_down, cnt, pwm_clr} = VEC[i][31:1];
      tick();
      check($sformatf("R%0d vec %0d", VEC[i][32:29], i), pwm_flag, VEC[i][0]);
    end
    pwm_clr = 1'b0; cnt = 12'd50; center_mode = 1'b0;

    // R11 gating
    evt_type = 2'b01; ch_lvl = 8'h04; pwm_irq_en = 1'b0; tick();
    ch_lvl = 8'h04;
    check("R11 irq masked", pwm_irq, 1'b0);
    pwm_irq_en = 1'b1; #1;
    check("R11 irq enabled", pwm_irq, 1'b1);

    // R10 fault flag
    flt_irq_en = 1'b0; flt_pin_evt = 1'b1; tick(); flt_pin_evt = 1'b0;
    check("R10 pin sets", flt_flag, 1'b1);
    check("R11 flt masked", flt_irq, 1'b0);
    tick();
    check("R10 sticky", flt_flag, 1'b1);
    pwm_clr = 1'b1; tick(); pwm_clr = 1'b0;
    check("R10 pwm clear independent", flt_flag, 1'b1);
    check("R8 pwm cleared", pwm_flag, 1'b0);
    flt_clr = 1'b1; tick(); flt_clr = 1'b0;
    check("R10 cleared", flt_flag, 1'b0);
    adc_cmp_evt = 1'b1; tick(); adc_cmp_evt = 1'b0;
    check("R10 adc sets", flt_flag, 1'b1);
    check("R10 pwm untouched", pwm_flag, 1'b0);
    flt_irq_en = 1'b1; #1;
    check("R11 flt enabled", flt_irq, 1'b1);
    flt_clr = 1'b1; adc_cmp_evt = 1'b1; tick(); adc_cmp_evt = 1'b0;
    check("R9 fault set beats clear", flt_flag, 1'b1);
    tick(); flt_clr = 1'b0;
    check("R10 cleared again", flt_flag, 1'b0);

    // R1 reset mid-run
    ch_lvl = 8'h00; evt_type = 2'b00; tick();
    check("R2 fall before reset", pwm_flag, 1'b1);
    rst_n = 1'b0; #1;
    check("R1 async reset", pwm_flag, 1'b0);
    check("R1 irq in reset", pwm_irq, 1'b0);
    tick(); rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule